// File: doc/BRIEF.md
# Asynchronous Serial Character Receiver

This block turns a serial input line into parallel characters. It samples the line on a receive-clock enable. That enable is divided by 1, 16 or 64, as a 2-bit divide field selects. The block finds the start of each character, then collects the data bits and the optional parity bit, and checks the first stop bit. A 3-bit format field picks one of eight character formats: 7 or 8 data bits, even, odd or no parity, and one or two stop bits.

Each finished character goes into a holding register, together with its framing-error and parity-error flags. A single-cycle read strobe tells the block that the consumer has taken the held character. If characters arrive faster than they are read, the block flags an overrun. The overrun flag is deferred until the character that was held before the overrun has been read. A carrier-loss input masks the full indication while it is high.

Top module: `serial_rx_core`

## Requirements
- R1: After reset, `rx_full`, `frame_err`, `parity_err` and `overrun` are all 0.
- R2: `div_sel` 00 samples one bit per `rx_tick`. In that mode a low line on the tick after a high one is taken as the start bit, and bit 0 is sampled on the next tick. `div_sel` 01 and 10 use 16 and 64 ticks per bit. In those modes the falling edge is confirmed half a bit later, and every later bit is sampled at its centre. Data bits arrive least significant bit first.
- R3: In divided modes, a low pulse shorter than half a bit is rejected. It produces no character, and the next valid character is received intact.
- R4: `word_sel` codes: 000 = 7 data bits, even parity, 2 stop bits; 001 = 7 bits, odd, 2 stop; 010 = 7 bits, even, 1 stop; 011 = 7 bits, odd, 1 stop; 100 = 8 bits, no parity, 2 stop; 101 = 8 bits, no parity, 1 stop; 110 = 8 bits, even, 1 stop; 111 = 8 bits, odd, 1 stop. In 7-bit formats, bit 7 of `rx_data` reads 0.
- R5: `frame_err` is 1 when the first stop bit of the held character was sampled low. It is updated with each transfer into the holding register.
- R6: `parity_err` is 1 when the held character's ones count, including the parity bit, does not match the selected parity. Even parity means an even total. In formats without parity the flag is 0.
- R7: A transfer sets `rx_full`. A read strobe with no overrun pending clears `rx_full` and `overrun`.
- R8: A character that completes while the holding register is full is dropped, and the held data is kept. `overrun` stays 0 until the next read. That read sets `overrun` and keeps `rx_full` at 1. The read after it clears both flags. Character framing carries on throughout, so the next character is received correctly.
- R9: While `carrier_off` is 1, `rx_full` reads 0. The held state is unchanged.
- R10: `div_sel` = 11 clears `rx_full`, `overrun`, `frame_err` and `parity_err`, and returns the receiver to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_tick | input | 1 | Receive clock enable, one cycle per receive clock |
| rx_line | input | 1 | Serial input, idle high |
| div_sel | input | 2 | Tick divide select; 11 clears the receiver |
| word_sel | input | 3 | Character format select |
| rd_strobe | input | 1 | One-cycle pulse: held character consumed |
| carrier_off | input | 1 | High when the carrier is lost; masks `rx_full` |
| rx_data | output | 8 | Held character |
| rx_full | output | 1 | Holding register full |
| frame_err | output | 1 | Held character missed its first stop bit |
| parity_err | output | 1 | Held character failed its parity check |
| overrun | output | 1 | One or more characters were lost |

## Verification
The hardest state to reach is the deferred overrun. It needs a second complete character to land while the first is still unread, and then two separate reads to walk the flags through their hidden, visible and cleared stages. The stimulus sends two frames back to back with no read strobe between them. It then checks the flags and the data after each read, and sends a third frame to show that framing survived. A sub-half-bit start glitch is driven on purpose to exercise the start re-check. Random characters then cover all formats, divide modes and injected stop and parity faults.

// File: rtl/rxs_pkg.sv
package rxs_pkg;

   localparam logic [1:0] DIV_ONE   = 2'b00;
   localparam logic [1:0] DIV_MID   = 2'b01;
   localparam logic [1:0] DIV_SLOW  = 2'b10;
   localparam logic [1:0] DIV_CLEAR = 2'b11;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_HUNT,
      ST_RUN
   } rx_state_e;

   typedef struct packed {
      logic eight;
      logic par_en;
      logic par_odd;
   } fmt_t;

   function automatic fmt_t decode_fmt(input logic [2:0] ws);
      fmt_t f;
      f.eight   = ws[2];
      f.par_en  = ~ws[2] | ws[1];
      f.par_odd = ws[0];
      return f;
   endfunction

endpackage

// File: rtl/rxs_bit_timer.sv
module rxs_bit_timer
   import rxs_pkg::*;
#(
   parameter int MID_DIV  = 16,
   parameter int SLOW_DIV = 64
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clr,
   input  logic       tick,
   input  logic       line,
   input  logic [1:0] div_sel,
   input  logic       last_bit,
   output logic       start_ok,
   output logic       bit_stb,
   output logic       bit_val
);
   localparam int CW = $clog2(SLOW_DIV);

   rx_state_e     state;
   logic [CW-1:0] cnt;
   logic [CW-1:0] div_m1;
   logic [CW-1:0] half_m1;
   logic          prev;
   logic          fall;

   always_comb begin
      case (div_sel)
         DIV_MID:  div_m1 = CW'(MID_DIV - 1);
         DIV_SLOW: div_m1 = CW'(SLOW_DIV - 1);
         default:  div_m1 = '0;
      endcase
   end

   assign half_m1  = div_m1 >> 1;
   assign fall     = tick && (state == ST_IDLE) && prev && !line;
   assign start_ok = (fall && (div_sel == DIV_ONE)) ||
                     (tick && (state == ST_HUNT) && (cnt == half_m1) && !line);
   assign bit_stb  = tick && (state == ST_RUN) && (cnt == div_m1);
   assign bit_val  = line;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         cnt   <= '0;
         prev  <= 1'b1;
      end else if (clr) begin
         state <= ST_IDLE;
         cnt   <= '0;
         prev  <= 1'b1;
      end else if (tick) begin
         prev <= line;
         case (state)
            ST_IDLE: begin
               cnt <= '0;
               if (fall) state <= (div_sel == DIV_ONE) ? ST_RUN : ST_HUNT;
            end
            ST_HUNT: begin
               if (cnt == half_m1) begin
                  cnt   <= '0;
                  state <= line ? ST_IDLE : ST_RUN;
               end else begin
                  cnt <= cnt + CW'(1);
               end
            end
            default: begin
               if (cnt == div_m1) begin
                  cnt <= '0;
                  if (last_bit) state <= ST_IDLE;
               end else begin
                  cnt <= cnt + CW'(1);
               end
            end
         endcase
      end
   end

endmodule

// File: rtl/rxs_framer.sv
module rxs_framer
   import rxs_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              start_ok,
   input  logic              bit_stb,
   input  logic              bit_val,
   input  logic [2:0]        word_sel,
   output logic              last_bit,
   output logic              done,
   output logic [DATA_W-1:0] char_o,
   output logic              fe_o,
   output logic              pe_o,
   output logic              cfg_eight,
   output logic              cfg_par
);
   localparam int IW = $clog2(DATA_W + 3);

   fmt_t              cfg;
   logic [IW-1:0]     idx;
   logic [IW-1:0]     nd;
   logic [DATA_W-1:0] sh;
   logic              pbit;

   assign nd        = cfg.eight ? IW'(DATA_W) : IW'(DATA_W - 1);
   assign last_bit  = (idx == nd + IW'(cfg.par_en));
   assign cfg_eight = cfg.eight;
   assign cfg_par   = cfg.par_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg    <= '0;
         idx    <= '0;
         sh     <= '0;
         pbit   <= 1'b0;
         done   <= 1'b0;
         char_o <= '0;
         fe_o   <= 1'b0;
         pe_o   <= 1'b0;
      end else if (clr) begin
         idx  <= '0;
         done <= 1'b0;
      end else begin
         done <= 1'b0;
         if (start_ok) begin
            cfg <= decode_fmt(word_sel);
            idx <= '0;
            sh  <= '0;
         end else if (bit_stb) begin
            for (int i = 0; i < DATA_W; i++)
               if ((idx == IW'(i)) && (idx < nd)) sh[i] <= bit_val;
            if (cfg.par_en && (idx == nd)) pbit <= bit_val;
            if (last_bit) begin
               done   <= 1'b1;
               char_o <= sh;
               fe_o   <= ~bit_val;
               pe_o   <= cfg.par_en & (^sh ^ pbit ^ cfg.par_odd);
            end else begin
               idx <= idx + IW'(1);
            end
         end
      end
   end

endmodule

// File: rtl/rxs_holding.sv
module rxs_holding #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              done,
   input  logic [DATA_W-1:0] char_i,
   input  logic              fe_i,
   input  logic              pe_i,
   input  logic              rd,
   output logic [DATA_W-1:0] data_q,
   output logic              full_q,
   output logic              ovr_q,
   output logic              pend_q,
   output logic              fe_q,
   output logic              pe_q,
   output logic              xfer
);
   logic eff_full;

   // Still occupied after this cycle's read is applied
   assign eff_full = full_q && (pend_q || !rd);
   assign xfer     = done && !eff_full;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= '0;
         full_q <= 1'b0;
         ovr_q  <= 1'b0;
         pend_q <= 1'b0;
         fe_q   <= 1'b0;
         pe_q   <= 1'b0;
      end else if (clr) begin
         full_q <= 1'b0;
         ovr_q  <= 1'b0;
         pend_q <= 1'b0;
         fe_q   <= 1'b0;
         pe_q   <= 1'b0;
      end else begin
         if (rd) begin
            if (pend_q) begin
               ovr_q  <= 1'b1;
               pend_q <= 1'b0;
            end else begin
               full_q <= 1'b0;
               ovr_q  <= 1'b0;
            end
         end
         if (xfer) begin
            data_q <= char_i;
            fe_q   <= fe_i;
            pe_q   <= pe_i;
            full_q <= 1'b1;
         end else if (done && !ovr_q && !(rd && pend_q)) begin
            pend_q <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/serial_rx_core.sv
module serial_rx_core
   import rxs_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int MID_DIV     = 16,
   parameter int SLOW_DIV    = 64,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_tick,
   input  logic              rx_line,
   input  logic [1:0]        div_sel,
   input  logic [2:0]        word_sel,
   input  logic              rd_strobe,
   input  logic              carrier_off,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_full,
   output logic              frame_err,
   output logic              parity_err,
   output logic              overrun
);
   if (MID_DIV < 4 || (MID_DIV & (MID_DIV - 1)) != 0) begin : g_bad_mid
      $error("MID_DIV must be a power of two of at least 4");
   end
   if (SLOW_DIV <= MID_DIV || (SLOW_DIV & (SLOW_DIV - 1)) != 0) begin : g_bad_slow
      $error("SLOW_DIV must be a power of two above MID_DIV");
   end
   if (DATA_W < 5) begin : g_bad_width
      $error("DATA_W must be at least 5");
   end
   if (SYNC_STAGES < 0) begin : g_bad_sync
      $error("SYNC_STAGES must not be negative");
   end

   logic              clr;
   logic              line_s;
   logic              start_ok, bit_stb, bit_val, last_bit;
   logic              done, fe_c, pe_c;
   logic [DATA_W-1:0] char_c;
   logic              full_raw, ovr_pend, xfer;
   logic              cfg_eight, cfg_par;

   assign clr = (div_sel == DIV_CLEAR);

   if (SYNC_STAGES == 0) begin : g_nosync
      assign line_s = rx_line;
   end else begin : g_sync
      logic [SYNC_STAGES-1:0] sr;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sr <= '1;
         else        sr <= SYNC_STAGES'({sr, rx_line});
      end
      assign line_s = sr[SYNC_STAGES-1];
   end

   rxs_bit_timer #(.MID_DIV(MID_DIV), .SLOW_DIV(SLOW_DIV)) u_timer (
      .clk(clk), .rst_n(rst_n), .clr(clr), .tick(rx_tick), .line(line_s),
      .div_sel(div_sel), .last_bit(last_bit), .start_ok(start_ok),
      .bit_stb(bit_stb), .bit_val(bit_val)
   );

   rxs_framer #(.DATA_W(DATA_W)) u_framer (
      .clk(clk), .rst_n(rst_n), .clr(clr), .start_ok(start_ok),
      .bit_stb(bit_stb), .bit_val(bit_val), .word_sel(word_sel),
      .last_bit(last_bit), .done(done), .char_o(char_c), .fe_o(fe_c),
      .pe_o(pe_c), .cfg_eight(cfg_eight), .cfg_par(cfg_par)
   );

   rxs_holding #(.DATA_W(DATA_W)) u_hold (
      .clk(clk), .rst_n(rst_n), .clr(clr), .done(done), .char_i(char_c),
      .fe_i(fe_c), .pe_i(pe_c), .rd(rd_strobe), .data_q(rx_data),
      .full_q(full_raw), .ovr_q(overrun), .pend_q(ovr_pend),
      .fe_q(frame_err), .pe_q(parity_err), .xfer(xfer)
   );

   assign rx_full = full_raw & ~carrier_off;

endmodule

// File: rtl/rxs_chk.sv
module rxs_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [1:0]        div_sel,
   input logic              rd_strobe,
   input logic [DATA_W-1:0] rx_data,
   input logic              full_raw,
   input logic              overrun,
   input logic              frame_err,
   input logic              parity_err,
   input logic              ovr_pend,
   input logic              xfer,
   input logic              cfg_eight,
   input logic              cfg_par
);
   p_mr_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (div_sel == 2'b11) |=> (!full_raw && !overrun && !frame_err && !parity_err));

   p_ovr_keeps_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
      overrun |-> full_raw);

   p_held_data_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (full_raw && !rd_strobe) |=> $stable(rx_data));

   p_read_drops_ovr_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_strobe && !ovr_pend && div_sel != 2'b11) |=> !overrun);

   p_no_parity_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer && !cfg_par) |=> !parity_err);

   p_top_bit_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer && !cfg_eight) |=> !rx_data[DATA_W-1]);
endmodule

bind serial_rx_core rxs_chk #(.DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .div_sel(div_sel), .rd_strobe(rd_strobe),
   .rx_data(rx_data), .full_raw(full_raw), .overrun(overrun),
   .frame_err(frame_err), .parity_err(parity_err), .ovr_pend(ovr_pend),
   .xfer(xfer), .cfg_eight(cfg_eight), .cfg_par(cfg_par)
);

// File: tb/tb_serial_rx_core.sv
`timescale 1ns/1ps
module tb_serial_rx_core;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rx_tick = 1'b0;
   logic       rx_line = 1'b1;
   logic [1:0] div_sel = 2'b01;
   logic [2:0] word_sel = 3'b101;
   logic       rd_strobe = 1'b0;
   logic       carrier_off = 1'b0;
   logic [7:0] rx_data;
   logic       rx_full, frame_err, parity_err, overrun;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;
   int tcnt = 0;

   always #10 clk = ~clk;

   always @(negedge clk) begin
      tcnt    <= (tcnt == 3) ? 0 : tcnt + 1;
      rx_tick <= (tcnt == 3);
   end

   serial_rx_core dut (
      .clk(clk), .rst_n(rst_n), .rx_tick(rx_tick), .rx_line(rx_line),
      .div_sel(div_sel), .word_sel(word_sel), .rd_strobe(rd_strobe),
      .carrier_off(carrier_off), .rx_data(rx_data), .rx_full(rx_full),
      .frame_err(frame_err), .parity_err(parity_err), .overrun(overrun)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wait_ticks(input int n);
      for (int k = 0; k < n; k++) begin
         @(posedge clk);
         while (!rx_tick) @(posedge clk);
      end
   endtask

   task automatic put_bit(input logic b, input int n);
      @(negedge clk);
      rx_line = b;
      wait_ticks(n);
   endtask

   function automatic int div_of(input logic [1:0] dv);
      return (dv == 2'b00) ? 1 : (dv == 2'b01) ? 16 : 64;
   endfunction

   function automatic logic [7:0] exp_char(input logic [7:0] b, input logic [2:0] ws);
      return ws[2] ? b : {1'b0, b[6:0]};
   endfunction

   function automatic logic par_used(input logic [2:0] ws);
      return ~ws[2] | ws[1];
   endfunction

   task automatic send_char(input logic [7:0] b, input logic [2:0] ws, input logic [1:0] dv,
                            input logic bad_par, input logic bad_stop);
      int n;
      int nd;
      logic p;
      n  = div_of(dv);
      nd = ws[2] ? 8 : 7;
      @(negedge clk);
      word_sel = ws;
      div_sel  = dv;
      wait_ticks(1);
      put_bit(1'b0, n);
      for (int i = 0; i < nd; i++) put_bit(b[i], n);
      if (par_used(ws)) begin
         p = (^exp_char(b, ws)) ^ ws[0] ^ bad_par;
         put_bit(p, n);
      end
      put_bit(~bad_stop, n);
      put_bit(1'b1, 2);
   endtask

   task automatic do_read();
      @(negedge clk);
      rd_strobe = 1'b1;
      @(negedge clk);
      rd_strobe = 1'b0;
      @(negedge clk);
   endtask

   task automatic report();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      finished = 1'b1;
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog expired");
         report();
      end
   end

   initial begin
      logic [7:0] b;
      logic [2:0] ws;
      logic [1:0] dv;
      logic bp, bs;
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 full", rx_full, 0);
      chk("R1 frame", frame_err, 0);
      chk("R1 parity", parity_err, 0);
      chk("R1 overrun", overrun, 0);
      rst_n = 1'b1;
      wait_ticks(2);

      // R2 R7: divide by 16, 8N1
      send_char(8'hA5, 3'b101, 2'b01, 0, 0);
      chk("R2 div16 data", rx_data, 8'hA5);
      chk("R7 full set", rx_full, 1);
      chk("R5 no frame err", frame_err, 0);
      do_read();
      chk("R7 full cleared", rx_full, 0);

      // R2: divide by 1 and 64
      send_char(8'h3C, 3'b101, 2'b00, 0, 0);
      chk("R2 div1 data", rx_data, 8'h3C);
      do_read();
      send_char(8'hD3, 3'b010, 2'b10, 0, 0);
      chk("R2 div64 data", rx_data, 8'h53);
      chk("R6 good even parity", parity_err, 0);
      do_read();

      // R4: 7-bit odd parity, top bit reads zero
      send_char(8'hFF, 3'b011, 2'b01, 0, 0);
      chk("R4 7-bit top zero", rx_data, 8'h7F);
      chk("R6 good odd parity", parity_err, 0);
      do_read();

      // R5: missing stop bit, then cleared by a good character
      send_char(8'h81, 3'b110, 2'b01, 0, 1);
      chk("R5 frame err set", frame_err, 1);
      chk("R5 data with frame err", rx_data, 8'h81);
      do_read();
      send_char(8'h18, 3'b110, 2'b01, 0, 0);
      chk("R5 frame err cleared", frame_err, 0);
      do_read();

      // R6: bad parity flagged; no-parity format ignores the fault request
      send_char(8'h2B, 3'b000, 2'b01, 1, 0);
      chk("R6 parity err even", parity_err, 1);
      do_read();
      send_char(8'h2B, 3'b100, 2'b01, 1, 0);
      chk("R6 no parity format", parity_err, 0);
      chk("R6 no parity data", rx_data, 8'h2B);
      do_read();

      // R3: short start glitch rejected
      put_bit(1'b0, 3);
      put_bit(1'b1, 40);
      chk("R3 glitch no char", rx_full, 0);
      send_char(8'h66, 3'b101, 2'b01, 0, 0);
      chk("R3 next char intact", rx_data, 8'h66);
      do_read();

      // R8: deferred overrun
      send_char(8'h11, 3'b101, 2'b01, 0, 0);
      send_char(8'h22, 3'b101, 2'b01, 0, 0);
      chk("R8 overrun hidden", overrun, 0);
      chk("R8 old data kept", rx_data, 8'h11);
      chk("R8 full held", rx_full, 1);
      do_read();
      chk("R8 overrun visible", overrun, 1);
      chk("R8 full after first read", rx_full, 1);
      chk("R8 data after first read", rx_data, 8'h11);
      do_read();
      chk("R8 overrun cleared", overrun, 0);
      chk("R8 full cleared", rx_full, 0);
      send_char(8'h33, 3'b101, 2'b01, 0, 0);
      chk("R8 sync kept", rx_data, 8'h33);

      // R9: carrier loss masks full
      @(negedge clk) carrier_off = 1'b1;
      @(negedge clk);
      chk("R9 masked", rx_full, 0);
      carrier_off = 1'b0;
      @(negedge clk);
      chk("R9 unmasked", rx_full, 1);
      do_read();

      // R10: clear code
      send_char(8'h5E, 3'b000, 2'b01, 1, 1);
      chk("R10 pre frame err", frame_err, 1);
      @(negedge clk) div_sel = 2'b11;
      @(negedge clk) div_sel = 2'b01;
      @(negedge clk);
      chk("R10 full cleared", rx_full, 0);
      chk("R10 frame cleared", frame_err, 0);
      chk("R10 parity cleared", parity_err, 0);

      // Random characters across formats and divides
      for (int r = 0; r < 30; r++) begin
         b  = 8'($urandom);
         ws = 3'($urandom);
         dv = ($urandom % 8 == 0) ? 2'b10 : 2'($urandom % 2);
         bp = ($urandom % 4 == 0);
         bs = ($urandom % 5 == 0);
         send_char(b, ws, dv, bp, bs);
         chk("R2 R4 random data", rx_data, exp_char(b, ws));
         chk("R5 random frame", frame_err, bs);
         chk("R6 random parity", parity_err, par_used(ws) & bp);
         chk("R7 random full", rx_full, 1);
         do_read();
         chk("R7 random read", rx_full, 0);
      end

      report();
   end
endmodule